// File: doc/BRIEF.md
# CAN bit timing generator

This block produces the quantum-level timing of one CAN bit from the system clock. A programmable divider turns the system clock into a time-quantum enable, and every bit is built from four consecutive segments: a one-quantum sync segment, a propagation segment, and two phase segments. The boundary between the two phase segments is the sample point. The block marks it with a one-clock strobe and latches the received bit there. The start of the sync segment is the transmit point and has its own strobe.

The receive line is read either once at the sample point or three times, on the last three quanta up to and including the sample point, with a majority vote. Recessive-to-dominant edges keep the bit in phase with the bus. An edge seen before the sample point lengthens the first phase segment. An edge seen after it shortens the second phase segment. Both adjustments are limited by the programmed jump width. While the attached controller reports idle, any such edge restarts the bit at the sync segment. Frame decoding, stuffing, arbitration and error handling are the job of the logic around this block.

Top module: `cbt_bit_timing`

## Requirements
- R1: `tq_o` is high for exactly one clock in every `presdiv_i`+1 clocks; with `presdiv_i` = 0 it is high on every clock. A quantum is processed at each clock edge where `tq_o` is high, and `rx_i` is read at that same edge.
- R2: Without edges, the quanta of a bit run in this fixed order: sync for 1 quantum, propagation for `prop_seg_i`+1, phase one for `ph1_seg_i`+1, then phase two for `ph2_seg_i`+1. `seg_o` reports the segment of the next quantum as 0 for sync, 1 for propagation, 2 for phase one and 3 for phase two. It changes only after a quantum edge.
- R3: `tx_pt_o` is high for one clock right after the quantum edge that processes a sync quantum.
- R4: `sample_o` is high for one clock right after the quantum edge that processes the last quantum of phase one. It is never high in the same clock as `tx_pt_o`.
- R5: With `triple_i` = 0, `rx_bit_o` takes the value of `rx_i` at the sample quantum edge. It changes only together with `sample_o`.
- R6: With `triple_i` = 1, `rx_bit_o` takes the majority of `rx_i` at the three quantum edges that end with the sample quantum edge.
- R7: An edge is a 1 at one quantum edge followed by a 0 at the next. If it occurs on a propagation or phase-one quantum at position p in the bit (sync is 0), with `idle_i` = 0, phase one is lengthened to its programmed length plus min(`rjw_i`+1, p). An edge on the last phase-one quantum therefore moves the sample point later.
- R8: An edge on a phase-two quantum with index c (from 0), with `idle_i` = 0, has an early amount e = `ph2_seg_i`+1−c. Phase two is shortened by min(`rjw_i`+1, e). If that shortening equals e, the quantum becomes the sync quantum of a new bit.
- R9: With `idle_i` = 1, an edge on any quantum makes that quantum the sync quantum of a new bit (hard synchronisation).
- R10: With `idle_i` = 0, an edge on a sync quantum changes nothing.
- R11: During reset and right after it, `seg_o` = 0, both strobes are low and `rx_bit_o` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_i | input | 1 | Receive line (1 = recessive) |
| idle_i | input | 1 | Controller idle; edges hard-synchronise |
| presdiv_i | input | PRESC_W | Quantum divider, ratio is value+1 |
| prop_seg_i | input | SEG_W | Propagation segment length minus one |
| ph1_seg_i | input | SEG_W | Phase one length minus one |
| ph2_seg_i | input | SEG_W | Phase two length minus one |
| rjw_i | input | RJW_W | Resync jump width minus one |
| triple_i | input | 1 | 1 = three-sample majority vote |
| tq_o | output | 1 | Time-quantum enable |
| tx_pt_o | output | 1 | Transmit point strobe |
| sample_o | output | 1 | Sample point strobe |
| rx_bit_o | output | 1 | Sampled bit value |
| seg_o | output | 2 | Segment of the next quantum |

## Verification
Two functions can meet on one quantum edge. A resync edge can land on the quantum that would close phase one, so lengthening and sampling compete. An early edge in phase two can also fall where the jump width covers the whole remaining segment, so the sync quantum and the transmit strobe move forward. The bench provokes the first case on purpose: it watches its own position model and pulls the line dominant exactly before the edge that would process the final phase-one quantum. Random edges, together with short segments and large jump widths, cover the second. In both cases the bench compares every output on every clock against a model that tracks an absolute quantum position in the bit. The expected result is a later sample strobe in the first case and an earlier transmit strobe in the second.

// File: rtl/cbt_pkg.sv
package cbt_pkg;
   typedef enum logic [1:0] {
      SEG_SYNC = 2'd0,
      SEG_PROP = 2'd1,
      SEG_PH1  = 2'd2,
      SEG_PH2  = 2'd3
   } seg_e;
endpackage

// File: rtl/cbt_prescaler.sv
module cbt_prescaler #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] div_i,
   output logic         tick_o
);
   logic [W-1:0] cnt_q;

   assign tick_o = (cnt_q == div_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (tick_o) cnt_q <= '0;
      else             cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/cbt_sampler.sv
module cbt_sampler #(
   parameter int DEPTH = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   input  logic rx_i,
   input  logic take_i,
   input  logic vote_i,
   output logic fall_o,
   output logic bit_o
);
   localparam int HW = DEPTH - 1;
   localparam int CW = $clog2(DEPTH + 1);

   logic [HW-1:0] hist_q;
   logic [CW-1:0] ones;
   logic          maj;

   // hist_q[0] holds the level seen at the previous quantum edge
   assign fall_o = tick_i & hist_q[0] & ~rx_i;

   generate
      if (HW > 1) begin : g_wide
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      hist_q <= '1;
            else if (tick_i) hist_q <= {hist_q[HW-2:0], rx_i};
         end
      end else begin : g_narrow
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      hist_q <= '1;
            else if (tick_i) hist_q <= rx_i;
         end
      end
   endgenerate

   always_comb begin
      ones = CW'(rx_i);
      for (int i = 0; i < HW; i++) ones = ones + CW'(hist_q[i]);
      maj = (ones > CW'(DEPTH / 2));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                bit_o <= 1'b1;
      else if (tick_i && take_i) bit_o <= vote_i ? maj : rx_i;
   end
endmodule

// File: rtl/cbt_seg_fsm.sv
module cbt_seg_fsm
   import cbt_pkg::*;
#(
   parameter int SEG_W = 3,
   parameter int RJW_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             fall_i,
   input  logic             idle_i,
   input  logic [SEG_W-1:0] prop_i,
   input  logic [SEG_W-1:0] ph1_i,
   input  logic [SEG_W-1:0] ph2_i,
   input  logic [RJW_W-1:0] rjw_i,
   output seg_e             seg_o,
   output logic             take_o,
   output logic             tx_o,
   output logic             smp_o
);
   localparam int MAXQ  = 1 + 3 * (1 << SEG_W) + (1 << RJW_W);
   localparam int POS_W = $clog2(MAXQ + 1);

   typedef logic [POS_W-1:0] pos_t;

   function automatic pos_t lesser(input pos_t a, input pos_t b);
      return (a < b) ? a : b;
   endfunction

   seg_e seg_q, seg_d;
   pos_t cnt_q, cnt_d, ext_q, ext_d, shr_q, shr_d;
   logic tx_d, take_d, restart;
   pos_t prop_x, ph1_x, ph2_x, rjq, pos_now, early, sh;

   always_comb begin
      prop_x  = POS_W'(prop_i);
      ph1_x   = POS_W'(ph1_i);
      ph2_x   = POS_W'(ph2_i);
      rjq     = POS_W'(rjw_i) + pos_t'(1);
      early   = ph2_x + pos_t'(1) - cnt_q;
      sh      = lesser(rjq, early);
      unique case (seg_q)
         SEG_PROP: pos_now = pos_t'(1) + cnt_q;
         SEG_PH1:  pos_now = prop_x + pos_t'(2) + cnt_q;
         default:  pos_now = '0;
      endcase

      seg_d   = seg_q;
      cnt_d   = cnt_q;
      ext_d   = ext_q;
      shr_d   = shr_q;
      take_d  = 1'b0;
      restart = 1'b0;

      if (tick_i) begin
         if (idle_i && fall_i) begin
            restart = 1'b1;
         end else begin
            unique case (seg_q)
               SEG_SYNC: restart = 1'b1;
               SEG_PROP: begin
                  if (fall_i) ext_d = lesser(rjq, pos_now);
                  if (cnt_q == prop_x) begin
                     seg_d = SEG_PH1;
                     cnt_d = '0;
                  end else begin
                     cnt_d = cnt_q + pos_t'(1);
                  end
               end
               SEG_PH1: begin
                  if (fall_i) ext_d = lesser(rjq, pos_now);
                  if (cnt_q == ph1_x + ext_d) begin
                     take_d = 1'b1;
                     seg_d  = SEG_PH2;
                     cnt_d  = '0;
                  end else begin
                     cnt_d = cnt_q + pos_t'(1);
                  end
               end
               default: begin
                  if (fall_i) begin
                     if (sh == early) restart = 1'b1;
                     else             shr_d   = sh;
                  end
                  if (!restart) begin
                     if (cnt_q == ph2_x - shr_d) begin
                        seg_d = SEG_SYNC;
                        cnt_d = '0;
                     end else begin
                        cnt_d = cnt_q + pos_t'(1);
                     end
                  end
               end
            endcase
         end
         if (restart) begin
            seg_d = SEG_PROP;
            cnt_d = '0;
            ext_d = '0;
            shr_d = '0;
         end
      end
      tx_d   = restart;
      take_o = take_d;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seg_q <= SEG_SYNC;
         cnt_q <= '0;
         ext_q <= '0;
         shr_q <= '0;
         tx_o  <= 1'b0;
         smp_o <= 1'b0;
      end else begin
         seg_q <= seg_d;
         cnt_q <= cnt_d;
         ext_q <= ext_d;
         shr_q <= shr_d;
         tx_o  <= tx_d;
         smp_o <= take_d;
      end
   end

   assign seg_o = seg_q;
endmodule

// File: rtl/cbt_bit_timing.sv
module cbt_bit_timing
   import cbt_pkg::*;
#(
   parameter int PRESC_W = 8,
   parameter int SEG_W   = 3,
   parameter int RJW_W   = 2,
   parameter int VOTE_N  = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rx_i,
   input  logic               idle_i,
   input  logic [PRESC_W-1:0] presdiv_i,
   input  logic [SEG_W-1:0]   prop_seg_i,
   input  logic [SEG_W-1:0]   ph1_seg_i,
   input  logic [SEG_W-1:0]   ph2_seg_i,
   input  logic [RJW_W-1:0]   rjw_i,
   input  logic               triple_i,
   output logic               tq_o,
   output logic               tx_pt_o,
   output logic               sample_o,
   output logic               rx_bit_o,
   output logic [1:0]         seg_o
);
   generate
      if (PRESC_W < 1 || SEG_W < 1 || RJW_W < 1) begin : g_bad_width
         $error("cbt_bit_timing: widths must be at least one bit");
      end
      if (VOTE_N < 3 || (VOTE_N % 2) == 0) begin : g_bad_vote
         $error("cbt_bit_timing: vote depth must be odd and at least three");
      end
   endgenerate

   logic tick, fall, take;
   seg_e seg;

   cbt_prescaler #(.W(PRESC_W)) u_presc (
      .clk    (clk),
      .rst_n  (rst_n),
      .div_i  (presdiv_i),
      .tick_o (tick)
   );

   cbt_sampler #(.DEPTH(VOTE_N)) u_samp (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_i (tick),
      .rx_i   (rx_i),
      .take_i (take),
      .vote_i (triple_i),
      .fall_o (fall),
      .bit_o  (rx_bit_o)
   );

   cbt_seg_fsm #(.SEG_W(SEG_W), .RJW_W(RJW_W)) u_fsm (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_i (tick),
      .fall_i (fall),
      .idle_i (idle_i),
      .prop_i (prop_seg_i),
      .ph1_i  (ph1_seg_i),
      .ph2_i  (ph2_seg_i),
      .rjw_i  (rjw_i),
      .seg_o  (seg),
      .take_o (take),
      .tx_o   (tx_pt_o),
      .smp_o  (sample_o)
   );

   assign tq_o  = tick;
   assign seg_o = seg;
endmodule

// File: rtl/cbt_bit_timing_chk.sv
module cbt_bit_timing_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       rx_i,
   input logic       triple_i,
   input logic       tq_o,
   input logic       tx_pt_o,
   input logic       sample_o,
   input logic       rx_bit_o,
   input logic [1:0] seg_o
);
   // R3
   tx_then_prop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_pt_o |-> seg_o == 2'd1);

   // R4
   sample_then_ph2_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sample_o |-> seg_o == 2'd3);

   // R1
   strobe_after_tq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_pt_o || sample_o) |-> $past(tq_o));

   // R2
   seg_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(tq_o) |-> $stable(seg_o));

   // R4
   no_dual_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(tx_pt_o && sample_o));

   // R5
   single_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_o && !triple_i) |-> rx_bit_o == $past(rx_i));

   // R5
   bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sample_o |-> $stable(rx_bit_o));
endmodule

bind cbt_bit_timing cbt_bit_timing_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .rx_i     (rx_i),
   .triple_i (triple_i),
   .tq_o     (tq_o),
   .tx_pt_o  (tx_pt_o),
   .sample_o (sample_o),
   .rx_bit_o (rx_bit_o),
   .seg_o    (seg_o)
);

// File: tb/cbt_bit_timing_tb.sv
module cbt_bit_timing_tb;
   localparam int PW = 8;
   localparam int SW = 3;
   localparam int RW = 2;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic          rst_n = 1'b0;
   logic          rx = 1'b1, idle = 1'b0, triple = 1'b0;
   logic [PW-1:0] presdiv = '0;
   logic [SW-1:0] prop = '0, ph1 = '0, ph2 = '0;
   logic [RW-1:0] rjw = '0;
   logic          tq, txp, smp, rbit;
   logic [1:0]    seg;

   cbt_bit_timing u_dut (
      .clk(clk), .rst_n(rst_n), .rx_i(rx), .idle_i(idle), .presdiv_i(presdiv),
      .prop_seg_i(prop), .ph1_seg_i(ph1), .ph2_seg_i(ph2), .rjw_i(rjw),
      .triple_i(triple), .tq_o(tq), .tx_pt_o(txp), .sample_o(smp),
      .rx_bit_o(rbit), .seg_o(seg)
   );

   int    n_chk = 0, n_fail = 0;
   bit    done = 0;
   string cur_req = "R2";
   logic [15:0] lfsr = 16'hACE1;
   int    hold = 0;

   // behavioural model: absolute quantum position within the bit
   int m_pc, m_pos, m_ext, m_shr, m_last, m_h1, m_h2;
   int e_tq, e_tx, e_smp, e_bit, e_seg;

   function automatic int mn(input int a, input int b);
      return (a < b) ? a : b;
   endfunction

   function automatic int last_ph1_pos();
      return (int'(prop) + 1) + (int'(ph1) + 1) + m_ext;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_pc = 0; m_pos = 0; m_ext = 0; m_shr = 0;
         m_last = 1; m_h1 = 1; m_h2 = 1;
         e_tx = 0; e_smp = 0; e_bit = 1;
      end else begin
         int  r, b1, c, early, sh, rj, l2;
         bit  tick, fall, restart;
         tick = (m_pc == int'(presdiv));
         m_pc = tick ? 0 : m_pc + 1;
         e_tx = 0; e_smp = 0;
         if (tick) begin
            r  = int'(rx);
            rj = int'(rjw) + 1;
            l2 = int'(ph2) + 1;
            fall = (m_last == 1) && (r == 0);
            restart = 0;
            if (idle && fall) restart = 1;
            else if (m_pos == 0) restart = 1;
            else begin
               b1 = last_ph1_pos();
               if (m_pos <= b1) begin
                  if (fall) m_ext = mn(rj, m_pos);
                  b1 = last_ph1_pos();
                  if (m_pos == b1) begin
                     e_smp = 1;
                     e_bit = triple ? (((m_h2 + m_h1 + r) >= 2) ? 1 : 0) : r;
                  end
                  m_pos = m_pos + 1;
               end else begin
                  c = m_pos - b1 - 1;
                  early = l2 - c;
                  if (fall) begin
                     sh = mn(rj, early);
                     if (sh == early) restart = 1;
                     else m_shr = sh;
                  end
                  if (!restart) m_pos = (m_pos == b1 + l2 - m_shr) ? 0 : m_pos + 1;
               end
            end
            if (restart) begin
               e_tx = 1; m_pos = 1; m_ext = 0; m_shr = 0;
            end
            m_h2 = m_h1; m_h1 = r; m_last = r;
         end
      end
      e_tq = (m_pc == int'(presdiv)) ? 1 : 0;
      if (m_pos == 0) e_seg = 0;
      else if (m_pos <= int'(prop) + 1) e_seg = 1;
      else if (m_pos <= last_ph1_pos()) e_seg = 2;
      else e_seg = 3;
   end

   task automatic check(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic setup(input int pd, input int pp, input int p1, input int p2,
                        input int rj, input bit tr, input bit idl, input string req);
      @(negedge clk);
      rst_n = 1'b0;
      presdiv = PW'(pd); prop = SW'(pp); ph1 = SW'(p1); ph2 = SW'(p2);
      rjw = RW'(rj); triple = tr; idle = idl; rx = 1'b1; hold = 0;
      cur_req = req;
      repeat (2) begin
         @(negedge clk);
         // R11 reset state
         check("R11", "seg_o", int'(seg), 0);
         check("R11", "tx_pt_o", int'(txp), 0);
         check("R11", "sample_o", int'(smp), 0);
         check("R11", "rx_bit_o", int'(rbit), 1);
      end
      rst_n = 1'b1;
   endtask

   // mode 0: random toggling, 1: edge on the last phase-one quantum, 2: edge on sync
   task automatic run(input int n, input int span, input int mode);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         check("R1", "tq_o", int'(tq), e_tq);
         check(cur_req, "seg_o", int'(seg), e_seg);
         check("R3", "tx_pt_o", int'(txp), e_tx);
         check("R4", "sample_o", int'(smp), e_smp);
         check(triple ? "R6" : "R5", "rx_bit_o", int'(rbit), e_bit);
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         if (hold > 0) hold--;
         else if (mode == 0) begin
            rx = ~rx;
            hold = 1 + int'(lfsr) % span;
         end else if (rx == 1'b0) begin
            rx = 1'b1;
            hold = 1 + int'(lfsr) % span;
         end else if (m_pc == int'(presdiv) && m_last == 1 &&
                      m_pos == ((mode == 1) ? last_ph1_pos() : 0)) begin
            rx = 1'b0;
            hold = int'(lfsr) % 3;
         end
      end
   endtask

   initial begin
      setup(2, 1, 2, 2, 1, 0, 0, "R2");   run(3000, 40, 0);
      setup(0, 0, 0, 0, 0, 1, 0, "R6");   run(3000, 6, 0);
      setup(255, 0, 1, 0, 0, 0, 0, "R1"); run(6000, 900, 0);
      setup(1, 7, 7, 7, 3, 0, 0, "R7");   run(5000, 30, 0);
      setup(1, 2, 6, 7, 0, 1, 0, "R8");   run(5000, 17, 0);
      setup(0, 0, 0, 3, 3, 0, 0, "R8");   run(4000, 5, 0);
      // R7 edge lands on the quantum that would hold the sample point
      setup(0, 3, 4, 5, 3, 0, 0, "R7");   run(4000, 5, 1);
      setup(1, 1, 2, 2, 1, 1, 0, "R7");   run(3000, 4, 1);
      setup(1, 1, 1, 1, 2, 0, 1, "R9");   run(3000, 11, 0);
      setup(0, 2, 2, 2, 3, 0, 0, "R10");  run(3000, 3, 2);
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      #2000000;
      if (!done) begin
         done = 1;
         n_fail++;
         $display("FAIL watchdog expired, actual=hung expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule